// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block sits on the inbound path of a bus bridge. It turns a 64-bit bus address, issued by a device behind one of two downstream ports, into a 54-bit system address. It also returns the barrier and MSI attributes that go with the access. The address range the bus address falls in selects one of five translation windows:

- a 64-bit direct window, which passes the address through;
- a 32-bit direct window, which takes its upper system bits from a per-port register;
- three windows that look up translation entries.

Of the three table windows, the 32-bit table window (256 KB pages) and the 40-bit super-page window (16 GB pages) share one entry array. The 40-bit window with 64 MB pages has its own array. The host fills both arrays, and the per-port direct registers, through simple write ports.

Each lookup presented with `in_valid` produces exactly one registered result one cycle later. The result is either a translated address with its attributes or an error. On an error the address and both attributes read as zero. A window code tells which window decoded the access.

Top module: `dma_xlate`

## Requirements
- R1: An address with bit 63 set translates directly: the output address is bits 53:0, the barrier output is bit 62, the MSI output is bit 61, and the window code is 1.
- R2: A direct 64-bit address that has any of bits 60:54 set gives an error, with window code 1.
- R3: An address from 0x8000_0000 to 0xFFFF_FFFF (window code 2) outputs {direct register of `in_port`, address bits 29:0}. The barrier output is address bit 30, and MSI is 0.
- R4: An address from 0 to 0x7FFF_FFFF (window code 3) clears bit 30 and reports it as the barrier. It reads shared entry addr[29:18] and outputs {entry address bits 53:18, addr[17:0]}. The MSI output is entry bit 62.
- R5: In window code 3, an entry index below 64 (these entries are kept for super pages) or at or above the shared table size gives an error.
- R6: An address from 0x40_0000_0000 to 0x7F_FFFF_FFFF (window code 4) reads separate-table entry addr[37:26] and outputs {entry bits 53:26, addr[25:0]}. The barrier output is always 0. An index at or above the separate table size gives an error.
- R7: An address from 0x80_0000_0000 to 0xFF_FFFF_FFFF (window code 5) reads shared entry `in_port`*32 + addr[38:34] and outputs {entry bits 53:34, addr[33:0]}. The barrier output is always 0.
- R8: A table window whose entry has bit 63 (valid) clear gives an error.
- R9: Any other address gives an error with window code 0. Every error outputs address 0, barrier 0 and MSI 0.
- R10: `out_valid` rises exactly one cycle after a cycle with `in_valid` high, and is low after a cycle with `in_valid` low.
- R11: After reset, `out_valid` is 0, every table entry is invalid and both direct registers are 0.
- R12: A table write with `tbl_sel`=0 targets the shared table and with `tbl_sel`=1 the separate table. A write to an index beyond the selected table changes nothing. A lookup in the same cycle as a write to its entry sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lookup request |
| in_addr | input | 64 | Inbound bus address |
| in_port | input | 1 | Downstream port of the requester (0 or 1) |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_sel | input | 1 | 0 = shared table, 1 = separate 64 MB table |
| tbl_idx | input | TIDX_W (8) | Entry index to write |
| tbl_wdata | input | 64 | Entry: valid in bit 63, MSI in bit 62, page address in bits 53:0 |
| dmap_we | input | 1 | Direct register write strobe |
| dmap_port | input | 1 | Port whose direct register is written |
| dmap_wdata | input | 24 | Upper system address bits for the 32-bit direct window |
| out_valid | output | 1 | Result valid |
| out_addr | output | 54 | System address (0 on error) |
| out_barrier | output | 1 | Barrier attribute |
| out_msi | output | 1 | MSI attribute |
| out_err | output | 1 | No valid mapping |
| out_win | output | 3 | Window code 0..5 |

## Verification
Every lookup result is due one clock edge after the edge that samples `in_valid`. The bench drives a request on a falling edge and removes it on the next falling edge, then reads every output at that same falling edge, which lies half a period after the capturing rising edge. Table and direct-register writes take effect at the edge that samples them, so a lookup issued on a later falling edge sees the new contents. The one exception is the same-cycle case, where the bench drives the write and the lookup together and expects the old entry. A follow-up idle cycle confirms that `out_valid` drops again one edge later.

// File: rtl/dma_xlate_pkg.sv
// dma_xlate_pkg: shared constants, window codes and the decode record
// for the inbound DMA address translator.
// Assumes: 64-bit bus addresses and 54-bit system addresses.
package dma_xlate_pkg;

    localparam int ADDR_W         = 64;
    localparam int SYS_W          = 54;
    localparam int D32_LOW_W      = 30;   // low bits kept by 32-bit windows
    localparam int DMAP_W         = SYS_W - D32_LOW_W;
    localparam int T40_SHIFT      = 26;   // 64 MB pages
    localparam int T40S_SHIFT     = 34;   // 16 GB pages
    localparam int SUPER_PER_PORT = 32;   // super-page entries per port
    localparam int LK_W           = 16;   // lookup index width before range check
    localparam int ENT_VALID_BIT  = 63;
    localparam int ENT_MSI_BIT    = 62;

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_D64  = 3'd1,
        WIN_D32  = 3'd2,
        WIN_T32  = 3'd3,
        WIN_T40  = 3'd4,
        WIN_T40S = 3'd5
    } win_e;

    typedef struct packed {
        win_e             win;
        logic             use_sep;   // lookup goes to the separate table
        logic [LK_W-1:0]  idx;       // table index
        logic             idx_ok;    // index lies inside the window's entries
        logic             barrier;
        logic             msi;       // direct-mode MSI attribute
        logic             fmt_err;   // reserved bits set in direct mode
        logic [SYS_W-1:0] offset;    // address bits carried into the result
        logic [SYS_W-1:0] mask;      // in-page offset mask (table windows)
    } dec_t;

endpackage

// File: rtl/dma_xlate_decode.sv
// dma_xlate_decode: classifies a bus address into one of five windows.
// It extracts the barrier bit, the table index with its range check, and
// the in-page offset and mask. Purely combinational.
// Assumes: two ports; super-page entries sit at the bottom of the shared table.
module dma_xlate_decode
    import dma_xlate_pkg::*;
#(
    parameter int SHARED_ENTRIES = 128,
    parameter int SEP_ENTRIES    = 64,
    parameter int T32_PAGE_SHIFT = 18
) (
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_port,
    output dec_t              dec
);

    localparam logic [LK_W-1:0] SH_LIM  = LK_W'(SHARED_ENTRIES);
    localparam logic [LK_W-1:0] SEP_LIM = LK_W'(SEP_ENTRIES);
    localparam logic [LK_W-1:0] RESV    = LK_W'(2 * SUPER_PER_PORT);
    localparam logic [SYS_W-1:0] T32_MASK  = SYS_W'((64'd1 << T32_PAGE_SHIFT) - 64'd1);
    localparam logic [SYS_W-1:0] T40_MASK  = SYS_W'((64'd1 << T40_SHIFT) - 64'd1);
    localparam logic [SYS_W-1:0] T40S_MASK = SYS_W'((64'd1 << T40S_SHIFT) - 64'd1);

    logic [LK_W-1:0] t32_idx;
    logic [LK_W-1:0] t40_idx;
    logic [LK_W-1:0] t40s_idx;

    // Page indices for each table window (the barrier bit is outside the t32 slice)
    always_comb begin
        t32_idx  = LK_W'(in_addr[D32_LOW_W-1:0] >> T32_PAGE_SHIFT);
        t40_idx  = LK_W'(in_addr[37:0] >> T40_SHIFT);
        t40s_idx = (LK_W'(in_port) * LK_W'(SUPER_PER_PORT))
                 + LK_W'(in_addr[38:0] >> T40S_SHIFT);
    end

    // Window classification and per-window fields
    always_comb begin
        dec = '0;
        if (in_addr[63]) begin
            dec.win     = WIN_D64;
            dec.offset  = in_addr[SYS_W-1:0];
            dec.barrier = in_addr[62];
            dec.msi     = in_addr[61];
            dec.fmt_err = |in_addr[60:54];
        end else if (in_addr[62:32] == '0 && in_addr[31]) begin
            dec.win     = WIN_D32;
            dec.barrier = in_addr[30];
            dec.offset  = SYS_W'(in_addr[D32_LOW_W-1:0]);
        end else if (in_addr[62:31] == '0) begin
            dec.win     = WIN_T32;
            dec.barrier = in_addr[30];
            dec.idx     = t32_idx;
            dec.idx_ok  = (t32_idx >= RESV) && (t32_idx < SH_LIM);
            dec.use_sep = 1'b0;
            dec.offset  = SYS_W'(in_addr[D32_LOW_W-1:0]);
            dec.mask    = T32_MASK;
        end else if (in_addr[62:39] == '0 && in_addr[38]) begin
            dec.win     = WIN_T40;
            dec.idx     = t40_idx;
            dec.idx_ok  = (t40_idx < SEP_LIM);
            dec.use_sep = 1'b1;
            dec.offset  = SYS_W'(in_addr[37:0]);
            dec.mask    = T40_MASK;
        end else if (in_addr[62:40] == '0 && in_addr[39]) begin
            dec.win     = WIN_T40S;
            dec.idx     = t40s_idx;
            dec.idx_ok  = (t40s_idx < SH_LIM);
            dec.use_sep = 1'b0;
            dec.offset  = SYS_W'(in_addr[38:0]);
            dec.mask    = T40S_MASK;
        end else begin
            dec.win     = WIN_NONE;
        end
    end

endmodule

// File: rtl/dma_xlate_table.sv
// dma_xlate_table: register array of translation entries (valid, MSI,
// page address). One write port and one combinational read port.
// Assumes: indices at or beyond ENTRIES write nothing and read as invalid.
module dma_xlate_table
    import dma_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_msi,
    input  logic [SYS_W-1:0] wr_addr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_msi,
    output logic [SYS_W-1:0] rd_addr
);

    logic             valid_q [ENTRIES];
    logic             msi_q   [ENTRIES];
    logic [SYS_W-1:0] addr_q  [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Entry i: cleared by reset, loaded when the write index matches
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                msi_q[i]   <= 1'b0;
                addr_q[i]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                valid_q[i] <= wr_valid;
                msi_q[i]   <= wr_msi;
                addr_q[i]  <= wr_addr;
            end
        end
    end

    // Read mux; an index that matches no entry returns an invalid entry
    always_comb begin
        rd_valid = 1'b0;
        rd_msi   = 1'b0;
        rd_addr  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_valid = valid_q[i];
                rd_msi   = msi_q[i];
                rd_addr  = addr_q[i];
            end
        end
    end

endmodule

// File: rtl/dma_xlate_dirmap.sv
// dma_xlate_dirmap: per-port upper-address registers for the 32-bit
// direct window. One write port and one combinational read port.
// Assumes: the port number always names an existing port.
module dma_xlate_dirmap #(
    parameter int NUM_PORTS = 2,
    parameter int W         = 24,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [W-1:0]      wr_data,
    input  logic [PORT_W-1:0] rd_port,
    output logic [W-1:0]      rd_data
);

    logic [W-1:0] map_q [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Register of port p: zero after reset, loaded on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[p] <= '0;
            end else if (wr_en && wr_port == PORT_W'(p)) begin
                map_q[p] <= wr_data;
            end
        end
    end

    // Select the requesting port's register
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == PORT_W'(p)) rd_data = map_q[p];
        end
    end

endmodule

// File: rtl/dma_xlate.sv
// dma_xlate: inbound DMA address translator (top). It decodes the window,
// reads the shared or separate entry table or the direct register, builds
// the system address and registers the result with one cycle of latency.
// Assumes: a lookup and a write to the same entry in one cycle see the old entry.
module dma_xlate
    import dma_xlate_pkg::*;
#(
    parameter int SHARED_ENTRIES = 128,
    parameter int SEP_ENTRIES    = 64,
    parameter int T32_PAGE_SHIFT = 18,
    localparam int TIDX_W = $clog2((SHARED_ENTRIES > SEP_ENTRIES) ? SHARED_ENTRIES : SEP_ENTRIES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_port,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [TIDX_W-1:0] tbl_idx,
    input  logic [63:0]       tbl_wdata,
    input  logic              dmap_we,
    input  logic              dmap_port,
    input  logic [DMAP_W-1:0] dmap_wdata,
    output logic              out_valid,
    output logic [SYS_W-1:0]  out_addr,
    output logic              out_barrier,
    output logic              out_msi,
    output logic              out_err,
    output logic [2:0]        out_win
);

    dec_t              dec;
    logic              sh_valid, sh_msi, sep_valid, sep_msi;
    logic [SYS_W-1:0]  sh_addr, sep_addr;
    logic [DMAP_W-1:0] dmap_rd;
    logic              ent_valid, ent_msi;
    logic [SYS_W-1:0]  ent_addr;
    logic              nx_err, nx_bar, nx_msi;
    logic [SYS_W-1:0]  nx_addr;
    logic              tbl_rsvd_unused;
    logic [LK_W-TIDX_W-1:0] idx_hi_unused;

    assign tbl_rsvd_unused = ^tbl_wdata[61:54];
    assign idx_hi_unused   = dec.idx[LK_W-1:TIDX_W];

    dma_xlate_decode #(
        .SHARED_ENTRIES (SHARED_ENTRIES),
        .SEP_ENTRIES    (SEP_ENTRIES),
        .T32_PAGE_SHIFT (T32_PAGE_SHIFT)
    ) u_dec (
        .in_addr (in_addr),
        .in_port (in_port),
        .dec     (dec)
    );

    dma_xlate_table #(.ENTRIES(SHARED_ENTRIES), .IDX_W(TIDX_W)) u_shared (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we && !tbl_sel),
        .wr_idx   (tbl_idx),
        .wr_valid (tbl_wdata[ENT_VALID_BIT]),
        .wr_msi   (tbl_wdata[ENT_MSI_BIT]),
        .wr_addr  (tbl_wdata[SYS_W-1:0]),
        .rd_idx   (dec.idx[TIDX_W-1:0]),
        .rd_valid (sh_valid),
        .rd_msi   (sh_msi),
        .rd_addr  (sh_addr)
    );

    dma_xlate_table #(.ENTRIES(SEP_ENTRIES), .IDX_W(TIDX_W)) u_sep (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we && tbl_sel),
        .wr_idx   (tbl_idx),
        .wr_valid (tbl_wdata[ENT_VALID_BIT]),
        .wr_msi   (tbl_wdata[ENT_MSI_BIT]),
        .wr_addr  (tbl_wdata[SYS_W-1:0]),
        .rd_idx   (dec.idx[TIDX_W-1:0]),
        .rd_valid (sep_valid),
        .rd_msi   (sep_msi),
        .rd_addr  (sep_addr)
    );

    dma_xlate_dirmap #(.NUM_PORTS(2), .W(DMAP_W)) u_dmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dmap_we),
        .wr_port (dmap_port),
        .wr_data (dmap_wdata),
        .rd_port (in_port),
        .rd_data (dmap_rd)
    );

    // Pick the entry of the table that the decoded window uses
    always_comb begin
        ent_valid = dec.use_sep ? sep_valid : sh_valid;
        ent_msi   = dec.use_sep ? sep_msi   : sh_msi;
        ent_addr  = dec.use_sep ? sep_addr  : sh_addr;
    end

    // Compose the next result per window; errors zero the address and attributes
    always_comb begin
        nx_err  = 1'b0;
        nx_bar  = 1'b0;
        nx_msi  = 1'b0;
        nx_addr = '0;
        unique case (dec.win)
            WIN_D64: begin
                nx_err  = dec.fmt_err;
                nx_addr = dec.offset;
                nx_bar  = dec.barrier;
                nx_msi  = dec.msi;
            end
            WIN_D32: begin
                nx_addr = {dmap_rd, dec.offset[D32_LOW_W-1:0]};
                nx_bar  = dec.barrier;
            end
            WIN_T32, WIN_T40, WIN_T40S: begin
                nx_err  = !dec.idx_ok || !ent_valid;
                nx_addr = (ent_addr & ~dec.mask) | (dec.offset & dec.mask);
                nx_bar  = dec.barrier;
                nx_msi  = ent_msi;
            end
            default: begin
                nx_err  = 1'b1;
            end
        endcase
        if (nx_err) begin
            nx_addr = '0;
            nx_bar  = 1'b0;
            nx_msi  = 1'b0;
        end
    end

    // Result register: one cycle from request to result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_barrier <= 1'b0;
            out_msi     <= 1'b0;
            out_err     <= 1'b0;
            out_win     <= WIN_NONE;
        end else begin
            out_valid   <= in_valid;
            out_addr    <= nx_addr;
            out_barrier <= nx_bar;
            out_msi     <= nx_msi;
            out_err     <= nx_err;
            out_win     <= dec.win;
        end
    end

endmodule

// File: rtl/dma_xlate_chk.sv
// dma_xlate_chk: port-level properties of the translator, bound to dma_xlate.
// Assumes: only the top-level ports are visible.
module dma_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_addr,
    input logic        out_valid,
    input logic [53:0] out_addr,
    input logic        out_barrier,
    input logic        out_msi,
    input logic        out_err,
    input logic [2:0]  out_win
);

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_d64_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[63] && in_addr[60:54] == 7'd0) |=>
        (!out_err && out_addr == $past(in_addr[53:0]) &&
         out_barrier == $past(in_addr[62]) && out_msi == $past(in_addr[61]) &&
         out_win == 3'd1));

    p_d64_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[63] && in_addr[60:54] != 7'd0) |=> out_err);

    p_d32_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[63:31] == 33'd1) |=>
        (!out_err && out_addr[29:0] == $past(in_addr[29:0]) &&
         out_barrier == $past(in_addr[30])));

    p_nobar40_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[63:38] == 26'd1) |=> !out_barrier);

    p_nobar40s_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[63:39] == 25'd1) |=> !out_barrier);

    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[63:38] == 26'd0 && in_addr[37:32] != 6'd0) |=>
        (out_err && out_win == 3'd0));

    p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_addr == 54'd0 && !out_barrier && !out_msi));

endmodule

bind dma_xlate dma_xlate_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_addr     (in_addr),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_barrier (out_barrier),
    .out_msi     (out_msi),
    .out_err     (out_err),
    .out_win     (out_win)
);

// File: tb/dma_xlate_tb_top.sv
// dma_xlate_tb_top: directed bench for the translator, one task per scenario.
module dma_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        in_port = 1'b0;
    logic        tbl_we = 1'b0;
    logic        tbl_sel = 1'b0;
    logic [7:0]  tbl_idx = '0;
    logic [63:0] tbl_wdata = '0;
    logic        dmap_we = 1'b0;
    logic        dmap_port = 1'b0;
    logic [23:0] dmap_wdata = '0;
    logic        out_valid;
    logic [53:0] out_addr;
    logic        out_barrier;
    logic        out_msi;
    logic        out_err;
    logic [2:0]  out_win;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_port(in_port), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .dmap_we(dmap_we), .dmap_port(dmap_port),
        .dmap_wdata(dmap_wdata), .out_valid(out_valid), .out_addr(out_addr),
        .out_barrier(out_barrier), .out_msi(out_msi), .out_err(out_err),
        .out_win(out_win)
    );

    localparam logic [53:0] E1 = 54'h0ABCDEF000000;   // 256 KB aligned
    localparam logic [53:0] E2 = 54'h3F000000000000;  // 64 MB aligned
    localparam logic [53:0] E3 = 54'h05000000000000;  // 16 GB aligned

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_ok(input string tag, input logic [53:0] a,
                             input logic bar, input logic msi, input logic [2:0] win);
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " err"}, 64'(out_err), 64'd0);
        chk({tag, " addr"}, 64'(out_addr), 64'(a));
        chk({tag, " barrier"}, 64'(out_barrier), 64'(bar));
        chk({tag, " msi"}, 64'(out_msi), 64'(msi));
        chk({tag, " win"}, 64'(out_win), 64'(win));
    endtask

    task automatic expect_err(input string tag, input logic [2:0] win);
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " err"}, 64'(out_err), 64'd1);
        chk({tag, " zero addr R9"}, 64'(out_addr), 64'd0);
        chk({tag, " zero attr R9"}, 64'({out_barrier, out_msi}), 64'd0);
        chk({tag, " win"}, 64'(out_win), 64'(win));
    endtask

    // One lookup: drive on a falling edge, result read at the next falling edge
    task automatic xlate(input logic [63:0] a, input logic p);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_port = p;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr_tbl(input logic sel, input logic [7:0] idx, input logic [63:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_idx = idx; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_dmap(input logic p, input logic [23:0] d);
        @(negedge clk);
        dmap_we = 1'b1; dmap_port = p; dmap_wdata = d;
        @(negedge clk);
        dmap_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 out_valid after reset", 64'(out_valid), 64'd0);
        xlate(64'h0000_0000_C000_0005, 1'b0);
        expect_ok("R11 direct reg zero", {24'h0, 30'h0000_0005}, 1'b1, 1'b0, 3'd2);
        xlate(64'h0000_0080_0000_0000, 1'b0);
        expect_err("R11 super entry invalid", 3'd5);
    endtask

    task automatic t_d64();
        logic [63:0] a;
        a = 64'hE000_0000_0000_0000 | 64'h0012_3456_789A_BCDE;
        xlate(a, 1'b0);
        expect_ok("R1 d64 attrs set", a[53:0], 1'b1, 1'b1, 3'd1);
        a = 64'h8000_0000_0000_0000 | 64'h0000_00FF_0000_1234;
        xlate(a, 1'b1);
        expect_ok("R1 d64 attrs clear", a[53:0], 1'b0, 1'b0, 3'd1);
        xlate(64'h8080_0000_0000_1000, 1'b0);
        expect_err("R2 d64 reserved bit", 3'd1);
    endtask

    task automatic t_d32();
        wr_dmap(1'b0, 24'hABCDE1);
        wr_dmap(1'b1, 24'h123456);
        xlate(64'h0000_0000_C123_4567, 1'b0);
        expect_ok("R3 d32 port0", {24'hABCDE1, 30'h0123_4567}, 1'b1, 1'b0, 3'd2);
        xlate(64'h0000_0000_8765_4321, 1'b1);
        expect_ok("R3 d32 port1", {24'h123456, 30'h0765_4321}, 1'b0, 1'b0, 3'd2);
    endtask

    task automatic t_t32();
        logic [63:0] a;
        wr_tbl(1'b0, 8'd70, {2'b11, 8'h00, E1});
        a = 64'h4000_0000 | (64'd70 << 18) | 64'h2_1234;
        xlate(a, 1'b0);
        expect_ok("R4 t32 hit", {E1[53:18], a[17:0]}, 1'b1, 1'b1, 3'd3);
        xlate(64'd71 << 18, 1'b0);
        expect_err("R8 t32 invalid entry", 3'd3);
        wr_tbl(1'b0, 8'd10, {2'b10, 8'h00, E1});
        xlate(64'd10 << 18, 1'b0);
        expect_err("R5 t32 index below 64", 3'd3);
        xlate(64'd200 << 18, 1'b0);
        expect_err("R5 t32 index beyond table", 3'd3);
    endtask

    task automatic t_t40();
        logic [63:0] a;
        wr_tbl(1'b1, 8'd19, {2'b10, 8'h00, E2});
        a = 64'h40_0000_0000 | (64'd19 << 26) | 64'h123_4567;
        xlate(a, 1'b0);
        expect_ok("R6 t40 hit no barrier", {E2[53:26], a[25:0]}, 1'b0, 1'b0, 3'd4);
        xlate(64'h40_0000_0000 | (64'd64 << 26), 1'b0);
        expect_err("R6 t40 index beyond table", 3'd4);
    endtask

    task automatic t_t40s();
        logic [63:0] a;
        wr_tbl(1'b0, 8'd37, {2'b11, 8'h00, E3});
        a = 64'h80_0000_0000 | (64'd5 << 34) | 64'h2_3456_789A;
        xlate(a, 1'b1);
        expect_ok("R7 t40s port1 hit", {E3[53:34], a[33:0]}, 1'b0, 1'b1, 3'd5);
        xlate(a, 1'b0);
        expect_err("R7 t40s port0 other entry", 3'd5);
    endtask

    task automatic t_none();
        xlate(64'h0000_0001_0000_0000, 1'b0);
        expect_err("R9 gap window", 3'd0);
        xlate(64'h0000_0100_0000_0000, 1'b1);
        expect_err("R9 above 40-bit", 3'd0);
    endtask

    task automatic t_writes();
        wr_tbl(1'b1, 8'd64, {2'b10, 8'h00, E2});
        xlate(64'h40_0000_0000, 1'b0);
        expect_err("R12 out-of-range write ignored", 3'd4);
        // lookup and write of the same entry in one cycle: old entry seen
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = 1'b0; tbl_idx = 8'd72; tbl_wdata = {2'b10, 8'h00, E1};
        in_valid = 1'b1; in_addr = 64'd72 << 18; in_port = 1'b0;
        @(negedge clk);
        tbl_we = 1'b0; in_valid = 1'b0;
        expect_err("R12 same-cycle old entry", 3'd3);
        xlate(64'd72 << 18, 1'b0);
        expect_ok("R12 write then lookup", E1, 1'b0, 1'b0, 3'd3);
    endtask

    task automatic t_latency();
        xlate(64'h8000_0000_0000_0040, 1'b0);
        chk("R10 valid one cycle after request", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R10 valid drops when idle", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_d64();
        t_d32();
        t_t32();
        t_t40();
        t_t40s();
        t_none();
        t_writes();
        t_latency();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule